// File: doc/BRIEF.md
# Backplane Interrupt Router and Controller

This block collects the interrupt pins of the boards in an eight-slot backplane and funnels them onto four shared backplane lines, A to D. Every slot has four local pins. The pins are rotated by slot position before they reach the backplane, so the same pin on neighbouring boards lands on different lines. Slots four positions apart end up sharing a line.

Each active pin is latched as pending per slot, so a request from one board is not lost while another board on the same line keeps requesting. The pending slots are merged into per-line pending flags. A per-line mask can hide a line from the processor. A single request output goes high while any unmasked line is pending.

The processor answers the request with an acknowledge strobe and receives a vector. The vector names only the winning line, where A has the highest priority. The processor then reads the per-slot status port to find which board raised the request, and it writes a per-slot clear to retire that board's request.

Top module: `bplane_irq_ctrl`

## Requirements
- R1: After reset, `irq` is low, `vec_valid` is low, `slot_active` and `line_pend` are all zero, and the line mask is zero, so every line is enabled.
- R2: Pin p of slot s is input bit `slot_pins[s*4+p]`. Slot 0 is the system slot, and p = 0..3 stands for pins A..D. The pin drives backplane line (s+p) mod 4, which is shown on `line_pend` bit 0..3 for lines A..D.
- R3: `irq` is high exactly when some pending line is not masked. It rises in the cycle after the clock edge that samples the pin.
- R4: When `iack` is high at a clock edge, `vec_valid` is high for that one following cycle only. `vec` then equals VEC_BASE plus the index of the lowest-numbered pending unmasked line. If no such line exists, `vec` equals VEC_BASE+4.
- R5: A pin that is high at a clock edge sets its slot's pending state. That state stays set after the pin drops, and `slot_active[s]` reports it, until the slot is cleared.
- R6: A clock edge with `clr_we` high clears all pending state of slot `clr_slot` and leaves other slots unchanged. A pin that is still high sets the state again at the next edge. A line stays pending while any other slot routed to it is active.
- R7: `mask_we` loads `mask_wdata` into the line mask (bit l is line l). A masked line is left out of `irq` and of the vector choice. `line_pend` and `slot_active` are not affected by the mask.
- R8: Two slots that share a line keep independent pending state. Repeated requests and clears on one of them never remove the other's pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_pins | input | NSLOTS*4 | Level interrupt pins, four per slot |
| mask_we | input | 1 | Load line mask |
| mask_wdata | input | 4 | New line mask, bit set means line hidden |
| clr_we | input | 1 | Clear one slot's pending state |
| clr_slot | input | $clog2(NSLOTS) | Slot to clear |
| iack | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | Request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec | output | VW | Vector naming the winning line |
| line_pend | output | 4 | Pending flag per backplane line, unmasked view |
| slot_active | output | NSLOTS | Pending status per slot |

## Verification
The bench sweeps every slot and pin on its own. A routing table that is off by one slot, or that rotates the wrong way, therefore shows up as the wrong line. It holds two boards on a shared line and retires one while the other keeps requesting. A controller that keeps state only per line would either lose a board or drop the line too early. The bench also clears a slot whose pin is still held, to check that the request comes back one edge later. It acknowledges with lines masked and with nothing pending. Here a mask that wipes the latched state, or a priority encoder that ignores the mask, would return the wrong vector instead of the spurious one.

// File: rtl/bplane_irq_ctrl.sv
module bplane_irq_ctrl #(
  parameter int NSLOTS = 8,
  parameter int VW = 8,
  parameter logic [VW-1:0] VEC_BASE = 8'h40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSLOTS*4-1:0]       slot_pins,
  input  logic                      mask_we,
  input  logic [3:0]                mask_wdata,
  input  logic                      clr_we,
  input  logic [$clog2(NSLOTS)-1:0] clr_slot,
  input  logic                      iack,
  output logic                      irq,
  output logic                      vec_valid,
  output logic [VW-1:0]             vec,
  output logic [3:0]                line_pend,
  output logic [NSLOTS-1:0]         slot_active
);
  localparam int NLINES = 4;
  localparam int SW = $clog2(NSLOTS);

  logic [NSLOTS*NLINES-1:0] pend;
  logic [NLINES-1:0]        mask, live;
  logic [2:0]               win;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else
      for (int s = 0; s < NSLOTS; s++)
        for (int p = 0; p < NLINES; p++)
          if (clr_we && clr_slot == SW'(s)) pend[s*NLINES+p] <= 1'b0;
          else if (slot_pins[s*NLINES+p])   pend[s*NLINES+p] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  genvar gs;
  generate
    for (gs = 0; gs < NSLOTS; gs++) begin : g_stat
      assign slot_active[gs] = |pend[gs*NLINES +: NLINES];
    end
  endgenerate

  always_comb begin
    line_pend = '0;
    for (int s = 0; s < NSLOTS; s++)
      for (int p = 0; p < NLINES; p++)
        if (pend[s*NLINES+p]) line_pend[(s+p)%NLINES] = 1'b1;
  end

  assign live = line_pend & ~mask;
  assign irq  = |live;

  always_comb begin
    win = 3'(NLINES);
    for (int l = NLINES-1; l >= 0; l--)
      if (live[l]) win = 3'(l);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      vec_valid <= iack;
      if (iack) vec <= VEC_BASE + VW'(win);
    end
  end
endmodule

module bplane_irq_ctrl_chk #(
  parameter int NSLOTS = 8,
  parameter int VW = 8,
  parameter logic [VW-1:0] VEC_BASE = 8'h40
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NSLOTS*4-1:0]       slot_pins,
  input logic                      mask_we,
  input logic                      clr_we,
  input logic [$clog2(NSLOTS)-1:0] clr_slot,
  input logic                      iack,
  input logic                      irq,
  input logic                      vec_valid,
  input logic [VW-1:0]             vec,
  input logic [3:0]                line_pend,
  input logic [NSLOTS-1:0]         slot_active
);
  p_irq_needs_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> line_pend != 4'b0);

  p_status_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active != '0) == (line_pend != 4'b0));

  p_vec_follows_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> vec_valid);

  p_vec_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |=> !vec_valid);

  p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec >= VEC_BASE && vec <= VEC_BASE + VW'(4)));

  p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_pins != '0 && !clr_we) |=> slot_active != '0);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && slot_pins[clr_slot*4 +: 4] == 4'b0) |=> !slot_active[$past(clr_slot)]);

  p_mask_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !clr_we) |=> (slot_active & $past(slot_active)) == $past(slot_active));
endmodule

bind bplane_irq_ctrl bplane_irq_ctrl_chk #(.NSLOTS(NSLOTS), .VW(VW), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_pins(slot_pins), .mask_we(mask_we),
  .clr_we(clr_we), .clr_slot(clr_slot), .iack(iack), .irq(irq),
  .vec_valid(vec_valid), .vec(vec), .line_pend(line_pend), .slot_active(slot_active));

// File: tb/bplane_irq_ctrl_test.sv
module bplane_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOTS = 8;
  localparam logic [7:0] BASE = 8'h40;

  logic clk = 0, rst_n = 0;
  logic [NSLOTS*4-1:0] slot_pins = '0;
  logic mask_we = 0, clr_we = 0, iack = 0;
  logic [3:0] mask_wdata = '0;
  logic [2:0] clr_slot = '0;
  logic irq, vec_valid;
  logic [7:0] vec;
  logic [3:0] line_pend;
  logic [NSLOTS-1:0] slot_active;
  int checks = 0, fails = 0;
  bit done = 0;

  bplane_irq_ctrl #(.NSLOTS(NSLOTS), .VW(8), .VEC_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .slot_pins(slot_pins), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .clr_we(clr_we), .clr_slot(clr_slot), .iack(iack),
    .irq(irq), .vec_valid(vec_valid), .vec(vec), .line_pend(line_pend),
    .slot_active(slot_active));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_slot(int s);
    clr_we = 1; clr_slot = 3'(s); tick(); clr_we = 0;
  endtask

  task automatic ack_expect(string req, logic [7:0] exp);
    iack = 1; tick(); iack = 0;
    chk({req, " vec_valid"}, 32'(vec_valid), 1);
    chk({req, " vec"}, 32'(vec), 32'(exp));
    tick();
    chk({req, " vec_valid drop"}, 32'(vec_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1 irq", 32'(irq), 0);
    chk("R1 vec_valid", 32'(vec_valid), 0);
    chk("R1 status", 32'(slot_active), 0);
    chk("R1 lines", 32'(line_pend), 0);
  endtask

  task automatic t_routing();
    for (int s = 0; s < NSLOTS; s++)
      for (int p = 0; p < 4; p++) begin
        slot_pins = '0; slot_pins[s*4+p] = 1'b1;
        tick();
        chk("R2 line", 32'(line_pend), 32'(1 << ((s+p)%4)));
        chk("R3 irq", 32'(irq), 1);
        slot_pins = '0;
        tick();
        chk("R5 held", 32'(slot_active), 32'(1 << s));
        clear_slot(s);
        chk("R6 cleared", 32'(slot_active), 0);
        chk("R3 irq low", 32'(irq), 0);
      end
  endtask

  task automatic t_priority();
    slot_pins = '0; slot_pins[1*4+0] = 1; slot_pins[3*4+0] = 1;
    tick(); slot_pins = '0;
    chk("R2 lines B,D", 32'(line_pend), 32'b1010);
    ack_expect("R4 prio", BASE + 8'd1);
    clear_slot(1);
    ack_expect("R4 next", BASE + 8'd3);
    clear_slot(3);
    ack_expect("R4 spurious", BASE + 8'd4);
  endtask

  task automatic t_mask();
    mask_wdata = 4'b0010; mask_we = 1; tick(); mask_we = 0;
    slot_pins[1*4+0] = 1; tick(); slot_pins = '0;
    chk("R7 line kept", 32'(line_pend), 32'b0010);
    chk("R7 status kept", 32'(slot_active), 32'b10);
    chk("R7 irq masked", 32'(irq), 0);
    ack_expect("R7 vec masked", BASE + 8'd4);
    slot_pins[0*4+0] = 1; tick(); slot_pins = '0;
    ack_expect("R7 vec skips B", BASE + 8'd0);
    mask_wdata = 4'b0000; mask_we = 1; tick(); mask_we = 0;
    chk("R7 unmask irq", 32'(irq), 1);
    chk("R7 unmask status", 32'(slot_active), 32'b11);
    clear_slot(0); clear_slot(1);
    chk("R6 all clear", 32'(slot_active), 0);
  endtask

  task automatic t_shared();
    slot_pins[2*4+0] = 1; tick(); slot_pins = '0;
    slot_pins[6*4+0] = 1;
    for (int i = 0; i < 4; i++) begin
      clear_slot(6);
      chk("R8 slot2 kept", 32'(slot_active[2]), 1);
    end
    chk("R8 line C", 32'(line_pend), 32'b0100);
    tick();
    clear_slot(2);
    chk("R6 slot2 gone", 32'(slot_active[2]), 0);
    chk("R6 line C still", 32'(line_pend), 32'b0100);
    ack_expect("R4 shared vec", BASE + 8'd2);
    slot_pins = '0; clear_slot(6);
    chk("R6 line C free", 32'(line_pend), 0);
  endtask

  task automatic t_relatch();
    slot_pins[0] = 1; tick();
    clear_slot(0);
    chk("R6 clear wins", 32'(slot_active[0]), 0);
    tick();
    chk("R6 relatch", 32'(slot_active[0]), 1);
    slot_pins = '0; clear_slot(0);
    chk("R6 final", 32'(slot_active), 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_routing();
    t_priority();
    t_mask();
    t_shared();
    t_relatch();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule